// File: doc/BRIEF.md
# Shift-Register Horizontal Line Counter

This block keeps the horizontal position within a video line. It uses a six-bit shift register with inverted-XOR feedback instead of a binary adder. On each clock with the enable high, the register shifts right by one place and takes a new top bit. A line has `LINE_LEN` positions. After the last one the counter returns to its home state and gives a one-cycle line-wrap pulse.

The position codes do not increase in value, so the block offers no magnitude comparison. Downstream logic instead supplies fixed six-bit patterns, and each pattern has its own match output. That output is high while the register holds that exact code.

The all-ones code feeds back onto itself and can never be part of the sequence. The home state is all zeros. If the register ever holds all ones, the next enabled clock moves it back to all zeros.

Top module: `lfsr_line_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads all zeros (`pos` = 0) and `line_wrap` loads 0, whatever the value of `en`.
- R2: On an enabled clock before the last position, the new `pos` is the old `pos` shifted right by one place. The new bit 5 is the inverse of (old bit 0 XOR old bit 1).
- R3: Starting from reset, the first `LINE_LEN` (57) enabled positions are all distinct, and none of them is 63.
- R4: On the enabled clock that leaves position index `LINE_LEN-1`, `pos` becomes 0 and `line_wrap` becomes 1. The next enabled clock clears `line_wrap`.
- R5: While `en` is low, `pos` and `line_wrap` keep their values.
- R6: `cmp_hit[k]` is high in the same cycle, combinationally, exactly when `pos` equals pattern k. Pattern k is `cmp_pat[6k+5:6k]`.
- R7: With `en` held high, `pos` comes back to 0 once every `LINE_LEN` clocks.
- R8: A reset in the middle of a line returns `pos` to 0 and restarts the sequence at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; the register advances on clocks where this is high |
| cmp_pat | input | 6*NUM_CMP | Compare patterns, six bits each; pattern k sits at bits 6k+5..6k |
| cmp_hit | output | NUM_CMP | Equality match, one bit per pattern |
| line_wrap | output | 1 | Line-wrap pulse, high for one enabled clock after the last position |
| pos | output | 6 | Raw shift-register state |

## Verification
The bench builds the block with its default values: a 57-position line and two compare channels. At that length the wrap decode sits at the real end-of-line code. With continuous enable, several full lines are walked through. That allows the distinctness and period checks, and it tests that wrap happens at index 56 and no other index. The two channels let one pattern be moved while the other stays fixed, which tests that the channels are independent. Stretches of random enable test the hold behaviour at every phase of the line, including while the wrap pulse is high.

// File: rtl/lfsr_line_pkg.sv
package lfsr_line_pkg;

    localparam int unsigned POS_W = 6;

    typedef logic [POS_W-1:0] pos_t;

    localparam pos_t HOME_POS = '0;
    localparam pos_t LOCK_POS = '1;

    typedef struct packed {
        logic wrap;
        pos_t pos;
    } line_state_t;

    // one shift: right by one, inverted XOR of the two low bits enters at the top
    function automatic pos_t lfsr_next(input pos_t cur);
        pos_t nxt;
        nxt            = cur >> 1;
        nxt[POS_W-1]   = ~(cur[0] ^ cur[1]);
        return nxt;
    endfunction

    // code reached after a number of shifts from the home state
    function automatic pos_t lfsr_at(input int unsigned steps);
        pos_t s;
        s = HOME_POS;
        for (int unsigned i = 0; i < steps; i++) begin
            s = lfsr_next(s);
        end
        return s;
    endfunction

endpackage

// File: rtl/lfsr_line_core.sv
module lfsr_line_core
    import lfsr_line_pkg::*;
#(
    parameter int unsigned LINE_LEN = 57
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    output line_state_t cur
);

    localparam pos_t END_POS = lfsr_at(LINE_LEN - 1);

    line_state_t nxt;
    logic        at_end;
    logic        locked;

    assign at_end = (cur.pos == END_POS);
    assign locked = (cur.pos == LOCK_POS);

    always_comb begin
        nxt = cur;
        if (en) begin
            nxt.wrap = at_end;
            if (at_end || locked) begin
                nxt.pos = HOME_POS;
            end else begin
                nxt.pos = lfsr_next(cur.pos);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{wrap: 1'b0, pos: HOME_POS};
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/lfsr_line_match.sv
module lfsr_line_match
    import lfsr_line_pkg::*;
#(
    parameter int unsigned NUM_CMP = 2
) (
    input  pos_t                     pos,
    input  logic [NUM_CMP*POS_W-1:0] pats,
    output logic [NUM_CMP-1:0]       hit
);

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_chan
        pos_t pat_k;
        assign pat_k  = pats[k*POS_W +: POS_W];
        assign hit[k] = (pos == pat_k);
    end

endmodule

// File: rtl/lfsr_line_counter.sv
module lfsr_line_counter
    import lfsr_line_pkg::*;
#(
    parameter int unsigned LINE_LEN = 57,
    parameter int unsigned NUM_CMP  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [NUM_CMP*POS_W-1:0] cmp_pat,
    output logic [NUM_CMP-1:0]       cmp_hit,
    output logic                     line_wrap,
    output logic [POS_W-1:0]         pos
);

    line_state_t st;

    lfsr_line_core #(
        .LINE_LEN (LINE_LEN)
    ) u_core (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .cur (st)
    );

    lfsr_line_match #(
        .NUM_CMP (NUM_CMP)
    ) u_match (
        .pos  (st.pos),
        .pats (cmp_pat),
        .hit  (cmp_hit)
    );

    assign pos       = st.pos;
    assign line_wrap = st.wrap;

endmodule

// File: rtl/lfsr_line_counter_chk.sv
module lfsr_line_counter_chk
    import lfsr_line_pkg::*;
#(
    parameter int unsigned LINE_LEN = 57,
    parameter int unsigned NUM_CMP  = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic [NUM_CMP*POS_W-1:0] cmp_pat,
    input logic [NUM_CMP-1:0]       cmp_hit,
    input logic                     line_wrap,
    input logic [POS_W-1:0]         pos
);

    localparam pos_t END_POS = lfsr_at(LINE_LEN - 1);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && pos != END_POS && pos != LOCK_POS) |=> (pos == lfsr_next($past(pos))));

    p_no_lock_r3: assert property (@(posedge clk) disable iff (rst)
        pos != LOCK_POS);

    p_wrap_home_r4: assert property (@(posedge clk) disable iff (rst)
        (en && pos == END_POS) |=> (pos == HOME_POS && line_wrap));

    p_wrap_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (en && line_wrap) |=> !line_wrap);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(pos) && $stable(line_wrap)));

    p_hit_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && $stable(cmp_pat)) |=> $stable(cmp_hit));

endmodule

bind lfsr_line_counter lfsr_line_counter_chk #(
    .LINE_LEN (LINE_LEN),
    .NUM_CMP  (NUM_CMP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cmp_pat   (cmp_pat),
    .cmp_hit   (cmp_hit),
    .line_wrap (line_wrap),
    .pos       (pos)
);

// File: tb/lfsr_line_counter_bench.sv
`timescale 1ns/1ps
module lfsr_line_counter_bench;

    localparam int LEN = 57;
    localparam int NC  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic [NC*6-1:0] cmp_pat;
    logic [NC-1:0]   cmp_hit;
    logic            line_wrap;
    logic [5:0]      pos;

    int n_cmp  = 0;
    int n_bad  = 0;
    int seq[LEN];
    int pat[NC];
    int idx    = 0;
    bit wrap_m = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lfsr_line_counter u_lfsr_line_counter (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .cmp_pat   (cmp_pat),
        .cmp_hit   (cmp_hit),
        .line_wrap (line_wrap),
        .pos       (pos)
    );

    always_comb begin
        for (int k = 0; k < NC; k++) cmp_pat[k*6 +: 6] = pat[k][5:0];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        chk(int'(pos) == seq[idx], req, int'(pos), seq[idx]);
        chk(line_wrap == wrap_m, req, int'(line_wrap), int'(wrap_m));
        for (int k = 0; k < NC; k++) begin
            chk(cmp_hit[k] == (seq[idx] == pat[k]), {req, "/R6"},
                int'(cmp_hit[k]), int'(seq[idx] == pat[k]));
        end
    endtask

    // inputs applied away from the rising edge; model advanced at the edge; compare at falling edge
    task automatic step(input bit r, input bit e, input string req);
        rst = r;
        en  = e;
        @(posedge clk);
        if (r) begin
            idx    = 0;
            wrap_m = 1'b0;
        end else if (e) begin
            wrap_m = (idx == LEN - 1);
            idx    = wrap_m ? 0 : idx + 1;
        end
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s;
        bit seen[64];
        int distinct;
        int gap;
        // sequence from the stated rule: shift right, top bit = NOT(b0 XOR b1)
        s = 0;
        for (int i = 0; i < LEN; i++) begin
            seq[i] = s;
            s = (s >> 1) | (((~(s ^ (s >> 1))) & 1) << 5);
        end
        pat[0] = seq[10];
        pat[1] = seq[LEN-1];

        // R1: reset with enable low and high
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        chk(pos == 6'd0, "R1", int'(pos), 0);
        chk(line_wrap == 1'b0, "R1", int'(line_wrap), 0);

        // R3 / R2: first line, distinct codes, never 63
        distinct = 0;
        for (int i = 0; i < 64; i++) seen[i] = 1'b0;
        for (int i = 0; i < LEN; i++) begin
            if (!seen[pos]) distinct++;
            seen[pos] = 1'b1;
            chk(pos != 6'd63, "R3", int'(pos), 0);
            if (i < LEN - 1) step(1'b0, 1'b1, "R2");
        end
        chk(distinct == LEN, "R3", distinct, LEN);

        // R4: wrap out of the last index
        step(1'b0, 1'b1, "R4");
        chk(line_wrap == 1'b1, "R4", int'(line_wrap), 1);
        chk(pos == 6'd0, "R4", int'(pos), 0);
        step(1'b0, 1'b1, "R4");
        chk(line_wrap == 1'b0, "R4", int'(line_wrap), 0);

        // R7: period under continuous enable, over several lines
        for (int line = 0; line < 3; line++) begin
            gap = 0;
            do begin
                step(1'b0, 1'b1, "R7");
                gap++;
            end while (pos != 6'd0 && gap < 2 * LEN);
            chk(gap == (line == 0 ? LEN - 1 : LEN), "R7", gap, (line == 0 ? LEN - 1 : LEN));
        end

        // R5: random enable across many line phases
        for (int i = 0; i < 600; i++) begin
            step(1'b0, ($urandom % 4) != 0, "R5");
        end
        // hold while the wrap pulse is high
        while (idx != LEN - 1) step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R4");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R5");
        chk(line_wrap == 1'b1, "R5", int'(line_wrap), 1);

        // R6: pattern moved during a hold changes the match in the same cycle
        en = 1'b0;
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1, "R2");
        en = 1'b0;
        pat[0] = int'(pos);
        #1;
        chk(cmp_hit[0] == 1'b1, "R6", int'(cmp_hit[0]), 1);
        chk(cmp_hit[1] == (int'(pos) == pat[1]), "R6", int'(cmp_hit[1]), int'(int'(pos) == pat[1]));
        pat[0] = 63;
        #1;
        chk(cmp_hit[0] == 1'b0, "R6", int'(cmp_hit[0]), 0);
        pat[1] = 0;
        @(negedge clk);
        for (int i = 0; i < 2 * LEN; i++) step(1'b0, 1'b1, "R6");

        // R8: reset mid-line restarts at index 0
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, "R2");
        step(1'b1, 1'b1, "R8");
        chk(pos == 6'd0, "R8", int'(pos), 0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R8");
        chk(int'(pos) == seq[5], "R8", int'(pos), seq[5]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule